// File: doc/BRIEF.md
# DMA Channel Interrupt Status Logic

This block keeps the interrupt side of one DMA channel: three enable bits, a set of sticky status flags and the single interrupt line that the channel presents to the processor. The transfer engine next to it sends one-cycle event pulses: a bus error, the end of a block, and a count strobe. The strobe comes with the remaining byte count and the programmed byte count. From the count values the block detects the two circular-buffer events: halfway through a pass, and pass finished.

Software reaches the block through a small word-addressed register port with three words. The enable word is at address 0, the status word at address 1 and the wrap-event select word at address 2. Status flags clear when software writes 1 to them. The interrupt line stays high while any flag whose enable is set is still standing.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset every enable bit, every select bit and every status flag is 0, `irq` is low, and all three words read as 0.
- R2: A write to address 0 stores data bits 0 (abort enable), 1 (done enable) and 2 (wrap enable). Address 0 reads back those three bits, and every other bit reads 0.
- R3: A pulse on `evt_abort` sets status bit 0, and a pulse on `evt_done` sets status bit 1, whatever the enables hold. Both flags stay set until software clears them.
- R4: A write to address 1 clears each of status bits 0, 1, 8 and 10 whose data bit is 1. Data bits that are 0 leave the flags unchanged.
- R5: When an event sets a flag in the same cycle as a write that clears it, the flag is set after that cycle.
- R6: On a count strobe, status bit 10 (half event) is set when all of these hold: the remaining count equals the programmed count shifted right by one, the programmed count is at least 2, wrap mode is active, the wrap enable is set and select bit 2 is set. With a programmed count of 32, this happens at a remaining count of 16.
- R7: On a count strobe, status bit 8 (wrap event) is set when all of these hold: the remaining count is 0, wrap mode is active, the wrap enable is set and select bit 0 is set.
- R8: Without a count strobe, with wrap mode inactive, with the wrap enable clear, or with the matching select bit clear, neither wrap flag is set.
- R9: `irq` is high exactly when abort flag AND abort enable, or done flag AND done enable, or (either wrap flag) AND wrap enable is true. Status bit 31 reads back `irq`.
- R10: A write to address 2 stores data bits 0 and 2 of the wrap-event select. Address 2 reads back only those bits. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address for write and read |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr` |
| evt_abort | input | 1 | Bus error pulse from engine |
| evt_done | input | 1 | Block finished pulse from engine |
| cnt_strobe | input | 1 | Remaining count has just been updated |
| wrap_mode | input | 1 | Source or destination address is in wrap mode |
| rem_count | input | 16 | Remaining byte count |
| prog_count | input | 16 | Programmed byte count |
| irq | output | 1 | Channel interrupt line |

## Verification
The hardest cases to reach are the narrow coincidences: a count strobe whose remaining count lands on exactly half or exactly zero while wrap mode, the wrap enable and the right select bit are all set, and an event arriving in the same cycle as a clearing write. Random stimulus draws the remaining count mostly from zero and from half the programmed count, and it draws event pulses and writes often enough that these situations overlap. Directed steps first walk a 32-byte pass through both wrap events and then collide an abort pulse with its own clear.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NFLAG  = 4;

  typedef enum logic [1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_STATUS = 2'd1,
    ADDR_WSEL   = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;

  // flag vector index
  localparam int unsigned F_ABORT = 0;
  localparam int unsigned F_DONE  = 1;
  localparam int unsigned F_WFULL = 2;
  localparam int unsigned F_WHALF = 3;

  // status word bit positions
  localparam int unsigned SB_ABORT = 0;
  localparam int unsigned SB_DONE  = 1;
  localparam int unsigned SB_WFULL = 8;
  localparam int unsigned SB_WHALF = 10;
  localparam int unsigned SB_IRQ   = 31;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_wrap_detect.sv
module irq_wrap_detect #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             cnt_strobe,
  input  logic             wrap_mode,
  input  logic             wrap_ie,
  input  logic             sel_half,
  input  logic             sel_full,
  input  logic [CNT_W-1:0] rem_count,
  input  logic [CNT_W-1:0] prog_count,
  output logic             hit_half,
  output logic             hit_full
);
  logic [CNT_W-1:0] half_mark;
  logic             armed;
  logic             half_valid;

  always_comb begin
    half_mark  = prog_count >> 1;
    half_valid = (half_mark != '0);
    armed      = cnt_strobe & wrap_mode & wrap_ie;
    hit_half   = armed & sel_half & half_valid & (rem_count == half_mark);
    hit_full   = armed & sel_full & (rem_count == '0);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic upd;
    always_comb begin
      upd       = set_i[i] | clr_i[i];
      flag_d[i] = flag_q[i];
      if (upd) flag_d[i] = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q[i] <= 1'b0;
      else if (upd) flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] rd_data,
  input  logic              evt_abort,
  input  logic              evt_done,
  input  logic              cnt_strobe,
  input  logic              wrap_mode,
  input  logic [CNT_W-1:0]  rem_count,
  input  logic [CNT_W-1:0]  prog_count,
  output logic              irq
);
  logic             srst_n;
  logic [2:0]       ie_q, ie_d;
  logic [1:0]       ws_q, ws_d;   // [1] half select, [0] full select
  logic             ie_en, ws_en;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic             hit_half, hit_full;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  // write decode
  always_comb begin
    ie_en = reg_wr & (reg_addr == ADDR_ENABLE);
    ws_en = reg_wr & (reg_addr == ADDR_WSEL);
    ie_d  = reg_wdata[2:0];
    ws_d  = {reg_wdata[2], reg_wdata[0]};
    flag_clr = '0;
    if (reg_wr && reg_addr == ADDR_STATUS) begin
      flag_clr[F_ABORT] = reg_wdata[SB_ABORT];
      flag_clr[F_DONE]  = reg_wdata[SB_DONE];
      flag_clr[F_WFULL] = reg_wdata[SB_WFULL];
      flag_clr[F_WHALF] = reg_wdata[SB_WHALF];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    ie_q <= '0;
    else if (ie_en) ie_q <= ie_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    ws_q <= '0;
    else if (ws_en) ws_q <= ws_d;
  end

  irq_wrap_detect #(.CNT_W(CNT_W)) u_wrap (
    .cnt_strobe(cnt_strobe),
    .wrap_mode (wrap_mode),
    .wrap_ie   (ie_q[2]),
    .sel_half  (ws_q[1]),
    .sel_full  (ws_q[0]),
    .rem_count (rem_count),
    .prog_count(prog_count),
    .hit_half  (hit_half),
    .hit_full  (hit_full)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[F_ABORT] = evt_abort;
    flag_set[F_DONE]  = evt_done;
    flag_set[F_WFULL] = hit_full;
    flag_set[F_WHALF] = hit_half;
  end

  irq_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(srst_n),
    .set_i(flag_set), .clr_i(flag_clr), .flag_o(flag_q)
  );

  assign irq = (flag_q[F_ABORT] & ie_q[0])
             | (flag_q[F_DONE]  & ie_q[1])
             | ((flag_q[F_WFULL] | flag_q[F_WHALF]) & ie_q[2]);

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (reg_addr)
      ADDR_ENABLE: rd_data[2:0] = ie_q;
      ADDR_STATUS: begin
        rd_data[SB_ABORT] = flag_q[F_ABORT];
        rd_data[SB_DONE]  = flag_q[F_DONE];
        rd_data[SB_WFULL] = flag_q[F_WFULL];
        rd_data[SB_WHALF] = flag_q[F_WHALF];
        rd_data[SB_IRQ]   = irq;
      end
      ADDR_WSEL: begin
        rd_data[0] = ws_q[0];
        rd_data[2] = ws_q[1];
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
(
  input logic              clk,
  input logic              srst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              evt_abort,
  input logic              evt_done,
  input logic              cnt_strobe,
  input logic              wrap_mode,
  input logic [NFLAG-1:0]  flags,
  input logic              irq
);
  logic st_wr;
  assign st_wr = reg_wr && (reg_addr == ADDR_STATUS);

  // R3: an abort pulse leaves the abort flag set
  a_r3_abort_sets: assert property (@(posedge clk) disable iff (!srst_n)
    evt_abort |=> flags[F_ABORT]);

  // R5: done event wins over a simultaneous clear
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!srst_n)
    (evt_done && st_wr && reg_wdata[SB_DONE]) |=> flags[F_DONE]);

  // R4: clear without a competing event empties the flag
  a_r4_clear_abort: assert property (@(posedge clk) disable iff (!srst_n)
    (st_wr && reg_wdata[SB_ABORT] && !evt_abort) |=> !flags[F_ABORT]);

  // R3: flag is sticky when no clear arrives
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (flags[F_DONE] && !(st_wr && reg_wdata[SB_DONE])) |=> flags[F_DONE]);

  // R8: no wrap mode and no write keeps wrap flags unchanged
  a_r8_wrap_gated: assert property (@(posedge clk) disable iff (!srst_n)
    (!wrap_mode && !reg_wr) |=> $stable(flags[F_WHALF:F_WFULL]));

  // R9: irq rises only after an event or a register write
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq) |-> $past(evt_abort || evt_done || cnt_strobe || reg_wr));
endmodule

bind irq_status_ctrl irq_status_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .evt_abort (evt_abort),
  .evt_done  (evt_done),
  .cnt_strobe(cnt_strobe),
  .wrap_mode (wrap_mode),
  .flags     (flag_q),
  .irq       (irq)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] rd_data;
  logic        evt_abort, evt_done, cnt_strobe, wrap_mode;
  logic [15:0] rem_count, prog_count;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  logic [2:0] m_ie;
  logic [1:0] m_ws;                 // [1] half, [0] full
  logic       m_ab, m_dn, m_wf, m_wh;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .evt_abort(evt_abort),
    .evt_done(evt_done), .cnt_strobe(cnt_strobe), .wrap_mode(wrap_mode),
    .rem_count(rem_count), .prog_count(prog_count), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic exp_irq();
    return (m_ab & m_ie[0]) | (m_dn & m_ie[1]) | ((m_wf | m_wh) & m_ie[2]);
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      2'd0: r[2:0] = m_ie;
      2'd1: begin
        r[0] = m_ab; r[1] = m_dn; r[8] = m_wf; r[10] = m_wh; r[31] = exp_irq();
      end
      2'd2: begin r[0] = m_ws[0]; r[2] = m_ws[1]; end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    evt_abort = 0; evt_done = 0; cnt_strobe = 0; wrap_mode = 0;
    rem_count = 16'd5; prog_count = 16'd32;
  endtask

  // one clock: compute model next state from current inputs, commit at the edge,
  // then compare outputs after the falling edge
  task automatic cycle(input string req);
    logic [2:0] n_ie; logic [1:0] n_ws;
    logic c_ab, c_dn, c_wf, c_wh, s_wf, s_wh, st;
    n_ie = m_ie; n_ws = m_ws;
    if (reg_wr && reg_addr == 2'd0) n_ie = reg_wdata[2:0];
    if (reg_wr && reg_addr == 2'd2) n_ws = {reg_wdata[2], reg_wdata[0]};
    st   = reg_wr && reg_addr == 2'd1;
    c_ab = st & reg_wdata[0]; c_dn = st & reg_wdata[1];
    c_wf = st & reg_wdata[8]; c_wh = st & reg_wdata[10];
    s_wf = cnt_strobe & wrap_mode & m_ie[2] & m_ws[0] & (rem_count == 16'd0);
    s_wh = cnt_strobe & wrap_mode & m_ie[2] & m_ws[1] & (prog_count >= 16'd2)
         & (rem_count == (prog_count >> 1));
    @(posedge clk);
    m_ab = evt_abort | (m_ab & ~c_ab);
    m_dn = evt_done  | (m_dn & ~c_dn);
    m_wf = s_wf | (m_wf & ~c_wf);
    m_wh = s_wh | (m_wh & ~c_wh);
    m_ie = n_ie; m_ws = n_ws;
    @(negedge clk);
    check({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
    check({req, " read"}, rd_data, exp_read(reg_addr));
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string req);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cycle(req);
    reg_wr = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_inputs();
    m_ie = 0; m_ws = 0; m_ab = 0; m_dn = 0; m_wf = 0; m_wh = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0];
      #1;
      check("R1 reset read", rd_data, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 / R10: readback masks reserved bits
    wr(2'd0, 32'hFFFF_FFFF, "R2");
    wr(2'd2, 32'hFFFF_FFFF, "R10");
    reg_addr = 2'd0; cycle("R2");
    reg_addr = 2'd3; cycle("R10");

    // R6 / R7: a 32-byte pass, half at 16, wrap at 0
    reg_addr = 2'd1; wrap_mode = 1; prog_count = 16'd32;
    cnt_strobe = 1; rem_count = 16'd16; cycle("R6");
    check("R6 half flag", {31'd0, rd_data[10]}, 32'd1);
    rem_count = 16'd0; cycle("R7");
    check("R7 wrap flag", {31'd0, rd_data[8]}, 32'd1);
    check("R9 pin readback", {31'd0, rd_data[31]}, 32'd1);
    cnt_strobe = 0;
    wr(2'd1, 32'h0000_0500, "R4");
    check("R4 wrap flags cleared", rd_data & 32'h0000_0500, 32'd0);

    // R8: wrap mode off
    wrap_mode = 0; cnt_strobe = 1; rem_count = 16'd0; cycle("R8");
    check("R8 no wrap flag", rd_data & 32'h0000_0500, 32'd0);
    cnt_strobe = 0;

    // R3 / R5: abort set, then collision with its own clear
    evt_abort = 1; cycle("R3"); evt_abort = 0;
    wr(2'd1, 32'd0, "R4 zero write");
    check("R4 zero write keeps", {31'd0, rd_data[0]}, 32'd1);
    evt_abort = 1; wr(2'd1, 32'd1, "R5"); evt_abort = 0;
    check("R5 event wins", {31'd0, rd_data[0]}, 32'd1);
    wr(2'd1, 32'd1, "R4");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned pick;
      reg_wr     = ($urandom % 4) == 0;
      reg_addr   = 2'($urandom % 4);
      reg_wdata  = $urandom;
      evt_abort  = ($urandom % 8) == 0;
      evt_done   = ($urandom % 8) == 0;
      cnt_strobe = ($urandom % 2) == 0;
      wrap_mode  = ($urandom % 4) != 0;
      prog_count = 16'($urandom % 8);
      if (($urandom % 2) == 0) prog_count = 16'($urandom);
      pick = $urandom % 3;
      rem_count = (pick == 0) ? 16'd0 : (pick == 1) ? (prog_count >> 1) : 16'($urandom);
      case (reg_addr)
        2'd0:    cycle("R2");
        2'd1:    cycle("R3 R4 R5 R6 R7 R8 R9");
        default: cycle("R10");
      endcase
    end
    clear_inputs();
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule